// File: doc/BRIEF.md
# Prioritised Background Window Generator

This block decides, for each character cell of an on-screen display, whether one of three rectangular background windows covers it and which colour fills it. The display timing logic presents the current cell row and cell column. One clock later the block returns a covered flag, a 3-bit RGB fill colour and an extra colour-select bit. A downstream character colour stage uses that bit to widen its palette inside the window.

Each window is set up through a byte-wide register write port. Its settings are an inclusive row range, an inclusive column range, an enable, the extra colour-select bit and an RGB colour. Where windows overlap, the lowest-numbered window wins. A window whose start lies beyond its end never covers anything. Two bits in the same register set give the polarity of the incoming horizontal and vertical sync. The block turns both sync inputs into active-high pulses, registered once.

Top module: `osd_bgwin`

## Requirements
- R1: After synchronous reset, win_active, win_rgb and win_cs are 0 and all nine configuration bytes are 0. Both polarity bits are therefore clear.
- R2: Window w (w = 0, 1, 2) takes bytes 3w, 3w+1 and 3w+2.
  - Byte 3w: bits 3:0 hold the row start and bits 7:4 the row end.
  - Byte 3w+1: bits 7:3 hold the column start, bit 2 the enable and bit 1 the colour-select bit.
  - Byte 3w+2: bits 7:3 hold the column end and bits 2:0 the colour, with R in bit 2, G in bit 1 and B in bit 0.
- R3: An enabled window covers a cell when row start ≤ row ≤ row end and column start ≤ column ≤ column end. All four comparisons are unsigned and include both bounds.
- R4: A window whose enable bit is 0 covers no cell.
- R5: A window whose row start exceeds its row end, or whose column start exceeds its column end, covers no cell.
- R6: When more than one window covers a cell, window 0 wins over windows 1 and 2, and window 1 wins over window 2. win_rgb and win_cs come from the winner.
- R7: When no window covers a cell, win_active, win_rgb and win_cs are all 0.
- R8: The result for the row and column present at a rising edge appears on the outputs right after that edge. It uses the configuration held before that edge.
- R9: A write to a byte address of 9 or more changes no configuration and no output.
- R10: Bit 0 of byte 1 selects horizontal sync polarity and bit 0 of byte 4 selects vertical sync polarity (0 = negative, 1 = positive). Each sync output is the registered sync input, inverted when its polarity bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration byte write strobe |
| wr_addr | input | 4 | Configuration byte address |
| wr_data | input | 8 | Configuration byte value |
| row_idx | input | 4 | Current cell row |
| col_idx | input | 5 | Current cell column |
| hsync_in | input | 1 | Incoming horizontal sync, polarity per configuration |
| vsync_in | input | 1 | Incoming vertical sync, polarity per configuration |
| win_active | output | 1 | A window covers the cell |
| win_rgb | output | 3 | Background colour of the winning window |
| win_cs | output | 1 | Colour-select bit of the winning window |
| hsync_out | output | 1 | Active-high horizontal sync |
| vsync_out | output | 1 | Active-high vertical sync |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it.
- The window outputs follow the row and column sampled at that edge.
- The sync outputs follow the sync inputs sampled at that edge.
- A configuration write takes effect at its edge and is first seen by the cell lookup at the following edge.

The bench drives all inputs on falling edges. It samples each window or sync result on the falling edge that follows the capturing rising edge. It always lets one write edge pass before it presents a new cell. This keeps every expected value tied to a single, known configuration.

// File: rtl/osd_bgwin_pkg.sv
package osd_bgwin_pkg;
  parameter int ROW_W     = 4;
  parameter int COL_W     = 5;
  parameter int RGB_W     = 3;
  parameter int NUM_WIN   = 3;
  parameter int BYTES_PW  = 3;
  parameter int BYTE_W    = 8;
  parameter int ADDR_W    = 4;
  localparam int NUM_BYTES = NUM_WIN * BYTES_PW;
  localparam int SEL_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  typedef struct packed {
    logic [ROW_W-1:0] row_lo;
    logic [ROW_W-1:0] row_hi;
    logic [COL_W-1:0] col_lo;
    logic [COL_W-1:0] col_hi;
    logic             en;
    logic             cs;
    logic [RGB_W-1:0] rgb;
  } win_cfg_t;
endpackage

// File: rtl/osd_bgwin_regs.sv
module osd_bgwin_regs
  import osd_bgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output win_cfg_t          cfg [NUM_WIN],
  output logic              hpol,
  output logic              vpol
);
  logic [BYTE_W-1:0] cfg_byte [NUM_BYTES];
  logic              addr_ok;

  assign addr_ok = (int'(wr_addr) < NUM_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BYTES; i++) cfg_byte[i] <= '0;
    end else if (wr_en && addr_ok) begin
      cfg_byte[wr_addr] <= wr_data;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_dec
    localparam int B0 = w * BYTES_PW;
    assign cfg[w].row_lo = cfg_byte[B0][ROW_W-1:0];
    assign cfg[w].row_hi = cfg_byte[B0][BYTE_W-1:BYTE_W-ROW_W];
    assign cfg[w].col_lo = cfg_byte[B0+1][BYTE_W-1:BYTE_W-COL_W];
    assign cfg[w].en     = cfg_byte[B0+1][2];
    assign cfg[w].cs     = cfg_byte[B0+1][1];
    assign cfg[w].col_hi = cfg_byte[B0+2][BYTE_W-1:BYTE_W-COL_W];
    assign cfg[w].rgb    = cfg_byte[B0+2][RGB_W-1:0];
  end

  assign hpol = cfg_byte[1][0];
  assign vpol = cfg_byte[BYTES_PW+1][0];

  logic [BYTE_W*NUM_BYTES-1:0] flat_cfg;
  always_comb
    for (int i = 0; i < NUM_BYTES; i++) flat_cfg[i*BYTE_W +: BYTE_W] = cfg_byte[i];

  p_oob_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_ok) |=> $stable(flat_cfg));

  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (flat_cfg == '0));
endmodule

// File: rtl/osd_bgwin_match.sv
module osd_bgwin_match
  import osd_bgwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  win_cfg_t         cfg,
  input  logic [ROW_W-1:0] row_idx,
  input  logic [COL_W-1:0] col_idx,
  output logic             hit
);
  logic in_rows, in_cols;

  assign in_rows = (row_idx >= cfg.row_lo) && (row_idx <= cfg.row_hi);
  assign in_cols = (col_idx >= cfg.col_lo) && (col_idx <= cfg.col_hi);
  assign hit     = cfg.en && in_rows && in_cols;

  p_inverted_range_r5: assert property (@(posedge clk) disable iff (rst)
    ((cfg.row_lo > cfg.row_hi) || (cfg.col_lo > cfg.col_hi)) |-> !hit);

  p_disabled_no_hit_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |-> !hit);
endmodule

// File: rtl/osd_bgwin_sync.sv
module osd_bgwin_sync (
  input  logic clk,
  input  logic rst,
  input  logic pol,
  input  logic sync_in,
  output logic sync_out
);
  always_ff @(posedge clk) begin
    if (rst) sync_out <= 1'b0;
    else     sync_out <= sync_in ^ ~pol;
  end

  p_neg_pol_inverts_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pol)) |-> (sync_out != $past(sync_in)));

  p_pos_pol_passes_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pol)) |-> (sync_out == $past(sync_in)));
endmodule

// File: rtl/osd_bgwin.sv
module osd_bgwin
  import osd_bgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COL_W-1:0]  col_idx,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic              win_active,
  output logic [RGB_W-1:0]  win_rgb,
  output logic              win_cs,
  output logic              hsync_out,
  output logic              vsync_out
);
  win_cfg_t           cfg [NUM_WIN];
  logic               hpol, vpol;
  logic [NUM_WIN-1:0] hit;
  logic               any_hit;
  logic [SEL_W-1:0]   sel;

  osd_bgwin_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .hpol(hpol), .vpol(vpol)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    osd_bgwin_match u_match (
      .clk(clk), .rst(rst), .cfg(cfg[w]),
      .row_idx(row_idx), .col_idx(col_idx), .hit(hit[w])
    );
  end

  // Lowest index wins: scan from the weakest window up so stronger ones override.
  always_comb begin
    sel = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--)
      if (hit[w]) sel = SEL_W'(w);
  end
  assign any_hit = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_active <= 1'b0;
      win_rgb    <= '0;
      win_cs     <= 1'b0;
    end else begin
      win_active <= any_hit;
      win_rgb    <= any_hit ? cfg[sel].rgb : '0;
      win_cs     <= any_hit ? cfg[sel].cs  : 1'b0;
    end
  end

  osd_bgwin_sync u_hsync (
    .clk(clk), .rst(rst), .pol(hpol), .sync_in(hsync_in), .sync_out(hsync_out)
  );
  osd_bgwin_sync u_vsync (
    .clk(clk), .rst(rst), .pol(vpol), .sync_in(vsync_in), .sync_out(vsync_out)
  );

  p_top_window_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit[0])) |-> (win_active && win_rgb == $past(cfg[0].rgb)
                                        && win_cs == $past(cfg[0].cs)));

  p_active_follows_hit_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (win_active == $past(any_hit)));

  p_idle_outputs_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !win_active |-> (win_rgb == '0 && !win_cs));
endmodule

// File: tb/osd_bgwin_tb.sv
module osd_bgwin_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] row_idx = '0;
  logic [4:0] col_idx = '0;
  logic       hsync_in = 1'b0, vsync_in = 1'b0;
  logic       win_active, win_cs, hsync_out, vsync_out;
  logic [2:0] win_rgb;

  int total = 0, bad = 0;
  logic [7:0] mdl [9];

  always #5ns clk = ~clk;

  osd_bgwin u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .row_idx(row_idx), .col_idx(col_idx), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .win_active(win_active), .win_rgb(win_rgb), .win_cs(win_cs),
    .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  // {active, cs, rgb} per the register layout and priority rules
  function automatic logic [4:0] exp_win(int r, int c);
    logic [4:0] res = '0;
    for (int w = 2; w >= 0; w--) begin
      logic [7:0] b0 = mdl[3*w], b1 = mdl[3*w+1], b2 = mdl[3*w+2];
      if (b1[2] && r >= int'(b0[3:0]) && r <= int'(b0[7:4]) &&
          c >= int'(b1[7:3]) && c <= int'(b2[7:3]))
        res = {1'b1, b1[1], b2[2:0]};
    end
    return res;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 9) mdl[a] = d;
  endtask

  task automatic probe(string req, int r, int c);
    @(negedge clk);
    row_idx = 4'(r); col_idx = 5'(c);
    @(negedge clk);
    check(req, {3'b0, win_active, win_cs, win_rgb}, {3'b0, exp_win(r, c)});
  endtask

  task automatic sync_step(string req, logic h, logic v);
    @(negedge clk);
    hsync_in = h; vsync_in = v;
    @(negedge clk);
    check(req, {6'b0, hsync_out, vsync_out},
          {6'b0, h ^ ~mdl[1][0], v ^ ~mdl[4][0]});
  endtask

  initial begin
    #2ms;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 9; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state, held in reset
    check("R1", {5'b0, win_active, win_cs, 1'b0}, 8'h00);
    check("R1", {5'b0, win_rgb}, 8'h00);
    @(negedge clk); rst = 1'b0;
    sync_step("R1 R10 reset polarity negative", 1'b1, 1'b0);
    probe("R1 R7 nothing configured", 0, 0);

    // Window 0: rows 2..5, cols 4..10, en, cs=1, rgb=5
    wr(0, 8'h52); wr(1, {5'd4, 3'b110}); wr(2, {5'd10, 3'd5});
    probe("R2 R3 inside", 3, 7);
    probe("R3 low corner", 2, 4);
    probe("R3 high corner", 5, 10);
    probe("R3 below row", 1, 7);
    probe("R3 past col", 5, 11);
    // Window 1 overlapping: rows 0..15, cols 0..31, cs=0, rgb=2
    wr(3, 8'hF0); wr(4, {5'd0, 3'b100}); wr(5, {5'd31, 3'd2});
    probe("R6 w0 over w1", 4, 8);
    probe("R6 w1 alone", 9, 20);
    // Window 2 everywhere, rgb=7 cs=1
    wr(6, 8'hF0); wr(7, {5'd0, 3'b110}); wr(8, {5'd31, 3'd7});
    probe("R6 w1 over w2", 12, 0);
    wr(4, {5'd0, 3'b000});
    probe("R4 w1 disabled, w2 shows", 12, 0);
    // R5 inverted ranges on window 2
    wr(6, 8'h38);
    probe("R5 row start above end", 4, 3);
    wr(6, 8'hF0); wr(7, {5'd20, 3'b110}); wr(8, {5'd19, 3'd7});
    probe("R5 col start above end", 4, 19);
    // R9 out-of-range writes
    for (int a = 9; a < 16; a++) wr(a, 8'hFF);
    probe("R9 after out-of-range writes", 12, 25);
    probe("R9 w0 intact", 3, 7);
    // R10 positive polarities
    wr(1, {5'd4, 3'b111}); wr(4, {5'd0, 3'b001});
    sync_step("R10 pos h, pos v", 1'b1, 1'b1);
    sync_step("R10 pos h, pos v low", 1'b0, 1'b0);
    wr(4, 8'h00);
    sync_step("R10 pos h, neg v", 1'b0, 1'b0);
    // R8 back-to-back cells, one cycle latency
    @(negedge clk); row_idx = 4'd3; col_idx = 5'd7;
    @(negedge clk);
    row_idx = 4'd14; col_idx = 5'd1;
    check("R8 first cell", {3'b0, win_active, win_cs, win_rgb}, {3'b0, exp_win(3, 7)});
    @(negedge clk);
    check("R8 second cell", {3'b0, win_active, win_cs, win_rgb}, {3'b0, exp_win(14, 1)});

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int k = int'($urandom_range(0, 9));
      if (k < 3) wr(int'($urandom_range(0, 15)), 8'($urandom));
      else if (k == 3) sync_step("R10 random", 1'($urandom), 1'($urandom));
      else probe("R3 R6 random", int'($urandom_range(0, 15)), int'($urandom_range(0, 31)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule